// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block is the register front end of one bus-master disk DMA channel. It holds a command byte, a status byte and a descriptor-table base address. Host software reaches them through a small byte-lane register port. From command writes it produces single-cycle start and stop events toward the descriptor engine. It also keeps the working table pointer that the engine begins from.

The drive's interrupt line is passed straight to the host. A high level also latches an interrupt flag in the status byte, and software clears that flag by writing a one to it. A stop request never cuts a transfer short: the channel stays active until the engine reports that its in-flight transfer is over. A separate cancel input lets the engine or the drive side drop the active state at once.

Top module: `dmac_regs`

## Requirements
- R1: A write with `bus_sel` = 0 (command) keeps only data bits 0 (start) and 3 (direction), so the stored byte is `bus_wdata[7:0] & 0x09`. A command read returns that byte, and `xfer_dir` shows bit 3.
- R2: A command write whose bit 0 equals the stored start bit takes no start or stop action. It raises no event and leaves `tbl_ptr` and `chan_active` alone, but it still updates the direction bit.
- R3: A command write that changes the start bit from 0 to 1 loads `tbl_ptr` from the base register. If the channel is inactive, the write also sets `chan_active`, and if `req_pending` is high it pulses `start_evt` for exactly one cycle after that edge.
- R4: A command write that changes the start bit from 1 to 0 while the channel is active ends the channel at the first clock edge, the write's own edge included, at which `xfer_busy` is low. At that edge `chan_active` falls and `stop_evt` pulses for one cycle.
- R5: A write with `bus_sel` = 2 (base) replaces only the addressed bytes of the base register. `bus_size` 0, 1 and 2 select 1, 2 and 4 bytes, starting at byte `bus_off`, and bits 1:0 of the result are always zero.
- R6: A read (`bus_valid` high, `bus_write` low) with `bus_sel` = 2 returns the base register shifted right by 8×`bus_off` and masked to the access width. `bus_rdata` is 0 whenever no read is presented.
- R7: `host_irq` follows `drv_irq` without delay. A high `drv_irq` at a clock edge sets the status interrupt flag, and a low level leaves the flag as it is.
- R8: A status read (`bus_sel` = 1) returns `chan_active` in bit 0 and the interrupt flag in bit 2, with all other bits zero. A status write with data bit 2 set clears the flag unless `drv_irq` is high in the same cycle, and a write with bit 2 clear has no effect.
- R9: `cancel` clears `chan_active` when it is set, without a `stop_evt` and without changing the stored command byte. It has no effect while the channel is inactive.
- R10: Reset clears the command byte, status flags, base register, working pointer and any pending stop. All event outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Register access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | 0 command, 1 status, 2 base, 3 unused |
| bus_off | input | 2 | Byte offset within the base register |
| bus_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| bus_wdata | input | 32 | Write data, low-aligned |
| bus_rdata | output | 32 | Read data, combinational |
| req_pending | input | 1 | Engine has a transfer request waiting |
| xfer_busy | input | 1 | Engine has a transfer in flight |
| cancel | input | 1 | Drop the active state |
| drv_irq | input | 1 | Interrupt level from the drive |
| host_irq | output | 1 | Interrupt level to the host |
| chan_active | output | 1 | Channel active state |
| xfer_dir | output | 1 | Stored direction bit |
| tbl_ptr | output | 32 | Working descriptor-table pointer |
| start_evt | output | 1 | One-cycle begin event to the engine |
| stop_evt | output | 1 | One-cycle end event to the engine |

## Verification
The embedded assertions check several rules on every cycle. A start event appears only on a rise of the active state, and no event follows a write that repeats the start bit. A busy transfer keeps the channel active unless cancel is raised, a stop event never coexists with an active channel, and the base register holds its value between writes. A high drive interrupt always leaves the flag set. The bench scenarios alone can show the byte-lane merge and read alignment values, the command mask, the pointer reload, the set-wins priority of the interrupt flag over its clear, and the reset values.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_BASE = 2'd2,
        SEL_NONE = 2'd3
    } dmac_sel_e;

    localparam logic [7:0] CMD_KEEP_MASK = 8'h09;
    localparam int         CMD_START_BIT = 0;
    localparam int         CMD_DIR_BIT   = 3;
    localparam int         STAT_ACT_BIT  = 0;
    localparam int         STAT_IRQ_BIT  = 2;

    typedef struct packed {
        logic [7:0] cmd;
        logic       active;
        logic       stop_pend;
        logic       start_evt;
        logic       stop_evt;
    } cmd_state_t;
endpackage

// File: rtl/dmac_cmd_ctl.sv
`timescale 1ns/1ps
module dmac_cmd_ctl
    import dmac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] wr_byte,
    input  logic       req_pending,
    input  logic       xfer_busy,
    input  logic       cancel,
    output logic [7:0] cmd_byte,
    output logic       active,
    output logic       start_evt,
    output logic       stop_evt,
    output logic       ptr_load
);
    cmd_state_t st_d, st_q;
    logic       new_start;

    always_comb begin
        st_d           = st_q;
        st_d.start_evt = 1'b0;
        st_d.stop_evt  = 1'b0;
        ptr_load       = 1'b0;
        new_start      = wr_byte[CMD_START_BIT];

        if (cmd_wr) begin
            if (new_start != st_q.cmd[CMD_START_BIT]) begin
                if (new_start) begin
                    ptr_load       = 1'b1;
                    st_d.stop_pend = 1'b0;
                    if (!st_q.active) begin
                        st_d.active    = 1'b1;
                        st_d.start_evt = req_pending;
                    end
                end else if (st_q.active) begin
                    st_d.stop_pend = 1'b1;
                end
            end
            st_d.cmd = wr_byte & CMD_KEEP_MASK;
        end

        if (st_d.stop_pend && !xfer_busy) begin
            st_d.active    = 1'b0;
            st_d.stop_pend = 1'b0;
            st_d.stop_evt  = 1'b1;
        end

        if (cancel && st_q.active) begin
            st_d.active    = 1'b0;
            st_d.stop_pend = 1'b0;
            st_d.start_evt = 1'b0;
            st_d.stop_evt  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_byte  = st_q.cmd;
    assign active    = st_q.active;
    assign start_evt = st_q.start_evt;
    assign stop_evt  = st_q.stop_evt;

    // R3
    start_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start_evt |-> (st_q.active && !$past(st_q.active)));
    // R2
    no_evt_same_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (wr_byte[CMD_START_BIT] == st_q.cmd[CMD_START_BIT])) |=> !st_q.start_evt);
    // R4
    busy_holds_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && xfer_busy && !cancel) |=> st_q.active);
    // R4
    stop_means_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stop_evt |-> !st_q.active);
    // R9
    cancel_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel && st_q.active) |=> (!st_q.active && !st_q.stop_evt));
endmodule

// File: rtl/dmac_base_reg.sv
`timescale 1ns/1ps
module dmac_base_reg #(
    parameter int AW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [$clog2(AW/8)-1:0] off,
    input  logic [1:0]          size,
    input  logic [AW-1:0]       wdata,
    input  logic                ptr_load,
    output logic [AW-1:0]       base,
    output logic [AW-1:0]       ptr
);
    localparam int NBYTES = AW / 8;
    localparam int SH_W   = $clog2(AW);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] ptr;
    } base_state_t;

    base_state_t   st_d, st_q;
    logic [AW-1:0] lane_mask;
    logic [AW-1:0] wmask;
    logic [AW-1:0] merged;
    logic [SH_W-1:0] shamt;

    always_comb begin
        case (size)
            2'd0:    lane_mask = AW'({8{1'b1}});
            2'd1:    lane_mask = AW'({16{1'b1}});
            default: lane_mask = '1;
        endcase
        shamt  = SH_W'({off, 3'b000});
        wmask  = lane_mask << shamt;
        merged = (st_q.base & ~wmask) | ((wdata << shamt) & wmask);
        merged[1:0] = 2'b00;

        st_d = st_q;
        if (wr)       st_d.base = merged;
        if (ptr_load) st_d.ptr  = st_q.base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base = st_q.base;
    assign ptr  = st_q.ptr;

    // R5
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(st_q.base));
    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_load |=> $stable(st_q.ptr));

    if (NBYTES < 1) begin : g_bad_width
        initial $display("dmac_base_reg: AW must be at least 8");
    end
endmodule

// File: rtl/dmac_irq_stat.sv
`timescale 1ns/1ps
module dmac_irq_stat (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_irq,
    input  logic clr_wr,
    output logic flag,
    output logic host_irq
);
    typedef struct packed {
        logic flag;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr)  st_d.flag = 1'b0;
        if (drv_irq) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag     = st_q.flag;
    assign host_irq = drv_irq;

    // R7
    irq_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_irq |=> st_q.flag);
    // R8
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_irq && !clr_wr) |=> $stable(st_q.flag));
endmodule

// File: rtl/dmac_regs.sv
`timescale 1ns/1ps
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [1:0]    bus_sel,
    input  logic [1:0]    bus_off,
    input  logic [1:0]    bus_size,
    input  logic [AW-1:0] bus_wdata,
    output logic [AW-1:0] bus_rdata,
    input  logic          req_pending,
    input  logic          xfer_busy,
    input  logic          cancel,
    input  logic          drv_irq,
    output logic          host_irq,
    output logic          chan_active,
    output logic          xfer_dir,
    output logic [AW-1:0] tbl_ptr,
    output logic          start_evt,
    output logic          stop_evt
);
    localparam int SH_W = $clog2(AW);

    dmac_sel_e     sel;
    logic          cmd_wr, stat_wr, base_wr, rd;
    logic [7:0]    cmd_byte;
    logic          ptr_load;
    logic          irq_flag;
    logic [AW-1:0] base;
    logic [AW-1:0] rd_mask;
    logic [7:0]    stat_byte;
    logic [SH_W-1:0] rd_sh;

    always_comb begin
        sel     = dmac_sel_e'(bus_sel);
        cmd_wr  = bus_valid && bus_write && (sel == SEL_CMD);
        stat_wr = bus_valid && bus_write && (sel == SEL_STAT) && bus_wdata[STAT_IRQ_BIT];
        base_wr = bus_valid && bus_write && (sel == SEL_BASE);
        rd      = bus_valid && !bus_write;
    end

    dmac_cmd_ctl u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .wr_byte     (bus_wdata[7:0]),
        .req_pending (req_pending),
        .xfer_busy   (xfer_busy),
        .cancel      (cancel),
        .cmd_byte    (cmd_byte),
        .active      (chan_active),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .ptr_load    (ptr_load)
    );

    dmac_base_reg #(.AW(AW)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (base_wr),
        .off      (bus_off[$clog2(AW/8)-1:0]),
        .size     (bus_size),
        .wdata    (bus_wdata),
        .ptr_load (ptr_load),
        .base     (base),
        .ptr      (tbl_ptr)
    );

    dmac_irq_stat u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .drv_irq  (drv_irq),
        .clr_wr   (stat_wr),
        .flag     (irq_flag),
        .host_irq (host_irq)
    );

    always_comb begin
        stat_byte               = '0;
        stat_byte[STAT_ACT_BIT] = chan_active;
        stat_byte[STAT_IRQ_BIT] = irq_flag;
        case (bus_size)
            2'd0:    rd_mask = AW'({8{1'b1}});
            2'd1:    rd_mask = AW'({16{1'b1}});
            default: rd_mask = '1;
        endcase
        rd_sh     = SH_W'({bus_off, 3'b000});
        bus_rdata = '0;
        if (rd) begin
            case (sel)
                SEL_CMD:  bus_rdata = AW'(cmd_byte);
                SEL_STAT: bus_rdata = AW'(stat_byte);
                SEL_BASE: bus_rdata = (base >> rd_sh) & rd_mask;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign xfer_dir = cmd_byte[CMD_DIR_BIT];

    // R1
    cmd_dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (xfer_dir == $past(bus_wdata[CMD_DIR_BIT])));
    // R6
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (bus_rdata == '0));
endmodule

// File: tb/dmac_regs_tb.sv
`timescale 1ns/1ps
module dmac_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_sel = '0, bus_off = '0, bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req_pending = 1'b0, xfer_busy = 1'b0, cancel = 1'b0, drv_irq = 1'b0;
    logic        host_irq, chan_active, xfer_dir, start_evt, stop_evt;
    logic [31:0] tbl_ptr;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    dmac_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_sel(bus_sel), .bus_off(bus_off), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_pending(req_pending),
        .xfer_busy(xfer_busy), .cancel(cancel), .drv_irq(drv_irq),
        .host_irq(host_irq), .chan_active(chan_active), .xfer_dir(xfer_dir),
        .tbl_ptr(tbl_ptr), .start_evt(start_evt), .stop_evt(stop_evt)
    );

    // {size, off, wdata, expected base after the write}
    localparam logic [67:0] VEC [6] = '{
        {2'd2, 2'd0, 32'h1234_5677, 32'h1234_5674},
        {2'd0, 2'd1, 32'h0000_00AB, 32'h1234_AB74},
        {2'd1, 2'd2, 32'h0000_BEEF, 32'hBEEF_AB74},
        {2'd0, 2'd0, 32'h0000_00FF, 32'hBEEF_ABFC},
        {2'd1, 2'd0, 32'h0000_0003, 32'hBEEF_0000},
        {2'd0, 2'd3, 32'h0000_1122, 32'h22EF_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [1:0] size,
                      input logic [1:0] off, input logic [31:0] data);
        bus_valid = 1'b1; bus_write = 1'b1; bus_sel = sel;
        bus_size = size; bus_off = off; bus_wdata = data;
        tick();
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [1:0] size,
                      input logic [1:0] off, output logic [31:0] data);
        bus_valid = 1'b1; bus_write = 1'b0; bus_sel = sel;
        bus_size = size; bus_off = off;
        #1 data = bus_rdata;
        bus_valid = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(2'd0, 2'd2, 2'd0, r); check("R10 cmd", r, 32'h0);
        rd(2'd1, 2'd2, 2'd0, r); check("R10 status", r, 32'h0);
        rd(2'd2, 2'd2, 2'd0, r); check("R10 base", r, 32'h0);
        check("R10 ptr/evt", {tbl_ptr[29:0], chan_active, start_evt}, 32'h0);

        // R5 byte-lane writes from the vector table
        for (int i = 0; i < 6; i++) begin
            wr(2'd2, VEC[i][67:66], VEC[i][65:64], VEC[i][63:32]);
            rd(2'd2, 2'd2, 2'd0, r);
            check("R5 base merge", r, VEC[i][31:0]);
        end

        // R6 aligned reads
        rd(2'd2, 2'd0, 2'd2, r); check("R6 byte@2", r, 32'h0000_00EF);
        rd(2'd2, 2'd1, 2'd1, r); check("R6 half@1", r, 32'h0000_EF00);
        rd(2'd2, 2'd0, 2'd3, r); check("R6 byte@3", r, 32'h0000_0022);
        #1 check("R6 idle rdata", bus_rdata, 32'h0);

        // R1 command mask, no start change
        wr(2'd0, 2'd0, 2'd0, 32'h0000_00FE);
        rd(2'd0, 2'd0, 2'd0, r); check("R1 cmd mask", r, 32'h08);
        check("R1 dir", {31'h0, xfer_dir}, 32'h1);
        check("R2 no start", {30'h0, chan_active, start_evt}, 32'h0);

        // R3 start with pending request
        req_pending = 1'b1;
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0009);
        check("R3 start evt", {30'h0, chan_active, start_evt}, 32'h3);
        check("R3 ptr load", tbl_ptr, 32'h22EF_0000);
        tick();
        check("R3 evt one cycle", {31'h0, start_evt}, 32'h0);

        // R2 repeated start bit
        wr(2'd2, 2'd2, 2'd0, 32'h0000_1000);
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0009);
        check("R2 no evt", {31'h0, start_evt}, 32'h0);
        check("R2 ptr kept", tbl_ptr, 32'h22EF_0000);
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        check("R2 dir only", {30'h0, xfer_dir, start_evt}, 32'h0);
        rd(2'd1, 2'd0, 2'd0, r); check("R8 status active", r, 32'h01);

        // R4 stop waits for busy
        xfer_busy = 1'b1;
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0000);
        check("R4 held", {30'h0, chan_active, stop_evt}, 32'h2);
        tick(); tick(); tick();
        check("R4 still held", {30'h0, chan_active, stop_evt}, 32'h2);
        xfer_busy = 1'b0;
        tick();
        check("R4 stopped", {30'h0, chan_active, stop_evt}, 32'h1);
        tick();
        check("R4 evt one cycle", {31'h0, stop_evt}, 32'h0);

        // R3 start without request
        req_pending = 1'b0;
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        check("R3 no req", {30'h0, chan_active, start_evt}, 32'h2);
        check("R3 ptr reload", tbl_ptr, 32'h0000_1000);

        // R4 stop with idle engine takes effect at write edge
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0000);
        check("R4 immediate", {30'h0, chan_active, stop_evt}, 32'h1);
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);

        // R9 cancel
        cancel = 1'b1; tick(); cancel = 1'b0;
        check("R9 cancel", {30'h0, chan_active, stop_evt}, 32'h0);
        rd(2'd0, 2'd0, 2'd0, r); check("R9 cmd kept", r, 32'h01);
        cancel = 1'b1; tick(); cancel = 1'b0;
        rd(2'd1, 2'd0, 2'd0, r); check("R9 idle cancel", r, 32'h00);
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        check("R2 after cancel", {30'h0, chan_active, start_evt}, 32'h0);

        // R7 interrupt pass-through and latch
        drv_irq = 1'b1;
        #1 check("R7 host high", {31'h0, host_irq}, 32'h1);
        @(negedge clk);
        rd(2'd1, 2'd0, 2'd0, r); check("R7 flag set", r, 32'h04);
        drv_irq = 1'b0;
        #1 check("R7 host low", {31'h0, host_irq}, 32'h0);
        @(negedge clk);
        tick();
        rd(2'd1, 2'd0, 2'd0, r); check("R7 flag kept", r, 32'h04);

        // R8 write-1-to-clear
        wr(2'd1, 2'd0, 2'd0, 32'h0000_0000);
        rd(2'd1, 2'd0, 2'd0, r); check("R8 zero write", r, 32'h04);
        wr(2'd1, 2'd0, 2'd0, 32'h0000_0004);
        rd(2'd1, 2'd0, 2'd0, r); check("R8 clear", r, 32'h00);
        drv_irq = 1'b1;
        wr(2'd1, 2'd0, 2'd0, 32'h0000_0004);
        rd(2'd1, 2'd0, 2'd0, r); check("R8 set wins", r, 32'h04);
        drv_irq = 1'b0;

        // R10 reset from busy state
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0000);
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0009);
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0, 2'd2, 2'd0, r); check("R10 cmd cleared", r, 32'h0);
        rd(2'd1, 2'd2, 2'd0, r); check("R10 status cleared", r, 32'h0);
        rd(2'd2, 2'd2, 2'd0, r); check("R10 base cleared", r, 32'h0);
        check("R10 ptr cleared", tbl_ptr, 32'h0);
        check("R10 outs", {28'h0, chan_active, start_evt, stop_evt, xfer_dir}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule